// File: doc/BRIEF.md
# Host Doorbell and Interrupt Router

This block turns two events into host interrupts. An embedded processor writes a 32-bit message word into a doorbell register, and that write raises a pending doorbell interrupt. A reply queue, which the embedded processor fills and the host drains, raises a second interrupt for as long as it holds at least one entry. The host sees both in a status word, can block either one with a mask word, and clears the doorbell with a write-one-to-clear strobe once it has read the message.

A two-bit routing field in the mask word steers the combined unmasked condition onto a primary pin, an alternate pin, both pins or neither pin. The pins are active low and are meant for an open-drain pad, so a high level means "released". When message-signalled interrupts are enabled, both pins stay released and the block instead emits a one-cycle request pulse each time the combined condition rises. A second small queue holds free request frames that the embedded processor posts and the host takes. Both host-side queue read ports return all ones when the queue is empty.

Top module: `hdb_irq_router`

## Requirements
- R1: After synchronous reset, status and mask read zero, both pins are high, `msi_req` is low, and both queue read ports return 0xFFFFFFFF.
- R2: A doorbell write by the embedded processor makes its data visible on `host_db_value` from the next cycle on and sets status bit 0.
- R3: A host status write with bit 0 set clears status bit 0. A status write with bit 0 clear has no effect. A doorbell write in the same cycle as a clear wins, so bit 0 stays set.
- R4: Status bit 3 is set exactly while the reply queue holds at least one entry, and it drops after the host pops the last entry.
- R5: The reply read port presents the oldest entry, and a pop advances it in first-in first-out order. When the queue is empty the port returns 0xFFFFFFFF and a pop has no effect.
- R6: The request read port presents posted free frames in first-in first-out order and returns 0xFFFFFFFF when no frame is available.
- R7: Each queue holds `QDEPTH` entries (default 4). A push while the queue is full is discarded.
- R8: Mask bit 0 blocks the doorbell source and mask bit 3 blocks the reply source from both pins and from `msi_req`. Neither mask bit clears its status bit.
- R9: Mask bits 9:8 route the combined condition as follows: 00 to the primary pin only, 01 to the alternate pin only, 10 to both pins, 11 to neither. An active pin is driven low.
- R10: While `msi_en` is high, both pins stay high regardless of status, mask or routing.
- R11: While `msi_en` is high, `msi_req` pulses high for exactly one cycle on each rising edge of the combined unmasked condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iop_db_we | input | 1 | Embedded processor doorbell write strobe |
| iop_db_data | input | 32 | Doorbell message word |
| host_db_value | output | 32 | Last doorbell word, readable by the host |
| host_stat_we | input | 1 | Host status write-one-to-clear strobe |
| host_stat_wdata | input | 32 | Host status write data (bit 0 clears the doorbell) |
| host_status | output | 32 | Status word: bit 0 doorbell, bit 3 reply |
| host_mask_we | input | 1 | Host mask write strobe |
| host_mask_wdata | input | 32 | Mask data: bit 0, bit 3, routing in 9:8 |
| host_mask | output | 32 | Mask word readback |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| rpl_push | input | 1 | Embedded processor posts a reply |
| rpl_push_data | input | 32 | Reply word |
| rpl_pop | input | 1 | Host pops the reply head |
| rpl_rdata | output | 32 | Reply head, or all ones when empty |
| free_push | input | 1 | Embedded processor posts a free request frame |
| free_push_data | input | 32 | Free frame address |
| req_pop | input | 1 | Host takes the request head |
| req_rdata | output | 32 | Free frame head, or all ones when empty |
| int_pri_n | output | 1 | Primary interrupt pin, active low |
| int_alt_n | output | 1 | Alternate interrupt pin, active low |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
The hardest condition to reach is a mask or routing change, or an MSI enable, while a source is already pending. The condition must still rise exactly once for a pulse to appear, and status must survive being masked. The bench raises the doorbell first and leaves it pending. It then walks a table of routing, MSI and mask settings and checks both pins and the status bit after each setting. It also drives a doorbell write and a clear into the same cycle, pops the reply queue when it is empty, and pushes into it when it is full.

// File: rtl/hdb_pkg.sv
package hdb_pkg;

    localparam int ST_DB_BIT  = 0;
    localparam int ST_RPL_BIT = 3;
    localparam int RT_LO      = 8;

    typedef enum logic [1:0] {
        ROUTE_PRI  = 2'b00,
        ROUTE_ALT  = 2'b01,
        ROUTE_BOTH = 2'b10,
        ROUTE_NONE = 2'b11
    } route_e;

    typedef struct packed {
        logic pri;
        logic alt;
    } pin_sel_t;

    function automatic pin_sel_t route_decode(route_e r);
        pin_sel_t s;
        s.pri = (r == ROUTE_PRI) || (r == ROUTE_BOTH);
        s.alt = (r == ROUTE_ALT) || (r == ROUTE_BOTH);
        return s;
    endfunction

endpackage

// File: rtl/hdb_fifo.sv
module hdb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '1 : mem[rptr];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == $past(cnt)));

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/hdb_doorbell.sv
module hdb_doorbell #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iop_we,
    input  logic [DW-1:0] iop_data,
    input  logic          clr,
    output logic [DW-1:0] db_value,
    output logic          db_pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            db_value <= '0;
            db_pend  <= 1'b0;
        end else begin
            if (iop_we) db_value <= iop_data;
            if (iop_we)   db_pend <= 1'b1;
            else if (clr) db_pend <= 1'b0;
        end
    end

    p_db_set_r2: assert property (@(posedge clk) disable iff (rst)
        iop_we |=> (db_pend && db_value == $past(iop_data)));

    p_db_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (clr && !iop_we) |=> !db_pend);

endmodule

// File: rtl/hdb_route.sv
module hdb_route
    import hdb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mask_we,
    input  logic   m_db_w,
    input  logic   m_rpl_w,
    input  route_e route_w,
    input  logic   src_db,
    input  logic   src_rpl,
    input  logic   msi_en,
    output logic   m_db,
    output logic   m_rpl,
    output route_e route_q,
    output logic   pri_n,
    output logic   alt_n,
    output logic   msi_req
);
    logic     cond, cond_d;
    pin_sel_t sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_db    <= 1'b0;
            m_rpl   <= 1'b0;
            route_q <= ROUTE_PRI;
            cond_d  <= 1'b0;
        end else begin
            if (mask_we) begin
                m_db    <= m_db_w;
                m_rpl   <= m_rpl_w;
                route_q <= route_w;
            end
            cond_d <= cond;
        end
    end

    always_comb begin
        cond    = (src_db && !m_db) || (src_rpl && !m_rpl);
        sel     = route_decode(route_q);
        pri_n   = !(cond && !msi_en && sel.pri);
        alt_n   = !(cond && !msi_en && sel.alt);
        msi_req = msi_en && cond && !cond_d;
    end

    p_msi_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        msi_en |-> (pri_n && alt_n));

    p_mask_block_r8: assert property (@(posedge clk) disable iff (rst)
        (m_db && m_rpl) |-> (pri_n && alt_n && !msi_req));

    p_route_none_r9: assert property (@(posedge clk) disable iff (rst)
        (route_q == ROUTE_NONE) |-> (pri_n && alt_n));

    p_pulse_once_r11: assert property (@(posedge clk) disable iff (rst)
        msi_req |=> !msi_req);

endmodule

// File: rtl/hdb_irq_router.sv
module hdb_irq_router
    import hdb_pkg::*;
#(
    parameter int DW     = 32,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iop_db_we,
    input  logic [DW-1:0] iop_db_data,
    output logic [DW-1:0] host_db_value,
    input  logic          host_stat_we,
    input  logic [DW-1:0] host_stat_wdata,
    output logic [DW-1:0] host_status,
    input  logic          host_mask_we,
    input  logic [DW-1:0] host_mask_wdata,
    output logic [DW-1:0] host_mask,
    input  logic          msi_en,
    input  logic          rpl_push,
    input  logic [DW-1:0] rpl_push_data,
    input  logic          rpl_pop,
    output logic [DW-1:0] rpl_rdata,
    input  logic          free_push,
    input  logic [DW-1:0] free_push_data,
    input  logic          req_pop,
    output logic [DW-1:0] req_rdata,
    output logic          int_pri_n,
    output logic          int_alt_n,
    output logic          msi_req
);
    logic   db_pend, rpl_empty, req_empty;
    logic   m_db, m_rpl;
    route_e route_q;
    logic   unused_bits;

    assign unused_bits = ^{host_stat_wdata[DW-1:1], host_mask_wdata[DW-1:RT_LO+2],
                           host_mask_wdata[RT_LO-1:ST_RPL_BIT+1],
                           host_mask_wdata[ST_RPL_BIT-1:1], req_empty};

    hdb_doorbell #(.DW(DW)) u_db (
        .clk      (clk),
        .rst      (rst),
        .iop_we   (iop_db_we),
        .iop_data (iop_db_data),
        .clr      (host_stat_we && host_stat_wdata[ST_DB_BIT]),
        .db_value (host_db_value),
        .db_pend  (db_pend)
    );

    hdb_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_rpl_q (
        .clk       (clk),
        .rst       (rst),
        .push      (rpl_push),
        .push_data (rpl_push_data),
        .pop       (rpl_pop),
        .rdata     (rpl_rdata),
        .empty     (rpl_empty)
    );

    hdb_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_req_q (
        .clk       (clk),
        .rst       (rst),
        .push      (free_push),
        .push_data (free_push_data),
        .pop       (req_pop),
        .rdata     (req_rdata),
        .empty     (req_empty)
    );

    hdb_route u_route (
        .clk     (clk),
        .rst     (rst),
        .mask_we (host_mask_we),
        .m_db_w  (host_mask_wdata[ST_DB_BIT]),
        .m_rpl_w (host_mask_wdata[ST_RPL_BIT]),
        .route_w (route_e'(host_mask_wdata[RT_LO+1:RT_LO])),
        .src_db  (db_pend),
        .src_rpl (!rpl_empty),
        .msi_en  (msi_en),
        .m_db    (m_db),
        .m_rpl   (m_rpl),
        .route_q (route_q),
        .pri_n   (int_pri_n),
        .alt_n   (int_alt_n),
        .msi_req (msi_req)
    );

    always_comb begin
        host_status              = '0;
        host_status[ST_DB_BIT]   = db_pend;
        host_status[ST_RPL_BIT]  = !rpl_empty;
        host_mask                = '0;
        host_mask[ST_DB_BIT]     = m_db;
        host_mask[ST_RPL_BIT]    = m_rpl;
        host_mask[RT_LO+1:RT_LO] = route_q;
    end

    p_reply_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (rpl_push && !rpl_pop) |=> host_status[ST_RPL_BIT]);

endmodule

// File: tb/tb_hdb_irq_router.sv
`timescale 1ns/1ps
module tb_hdb_irq_router;
    logic        clk = 1'b0;
    logic        rst;
    logic        iop_db_we, host_stat_we, host_mask_we, msi_en;
    logic [31:0] iop_db_data, host_stat_wdata, host_mask_wdata;
    logic [31:0] host_db_value, host_status, host_mask;
    logic        rpl_push, rpl_pop, free_push, req_pop;
    logic [31:0] rpl_push_data, rpl_rdata, free_push_data, req_rdata;
    logic        int_pri_n, int_alt_n, msi_req;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    hdb_irq_router dut (.*);

    // {route[1:0], msi, mask_db, exp_pri_n, exp_alt_n}
    localparam logic [5:0] VEC [8] = '{
        6'b00_0_0_0_1, 6'b01_0_0_1_0, 6'b10_0_0_0_0, 6'b11_0_0_1_1,
        6'b10_1_0_1_1, 6'b00_0_1_1_1, 6'b01_0_1_1_1, 6'b10_0_1_1_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        iop_db_we = 0; host_stat_we = 0; host_mask_we = 0;
        rpl_push = 0; rpl_pop = 0; free_push = 0; req_pop = 0;
    endtask

    task automatic db_write(input logic [31:0] d);
        iop_db_we = 1; iop_db_data = d; tick();
    endtask

    task automatic stat_write(input logic [31:0] d);
        host_stat_we = 1; host_stat_wdata = d; tick();
    endtask

    task automatic mask_write(input logic [31:0] d);
        host_mask_we = 1; host_mask_wdata = d; tick();
    endtask

    task automatic rpl_in(input logic [31:0] d);
        rpl_push = 1; rpl_push_data = d; tick();
    endtask

    task automatic rpl_take(input string req, input logic [31:0] exp);
        chk(req, rpl_rdata, exp);
        rpl_pop = 1; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1; msi_en = 0;
        iop_db_we = 0; host_stat_we = 0; host_mask_we = 0;
        rpl_push = 0; rpl_pop = 0; free_push = 0; req_pop = 0;
        iop_db_data = 0; host_stat_wdata = 0; host_mask_wdata = 0;
        rpl_push_data = 0; free_push_data = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 status", host_status, 32'h0);
        chk("R1 mask", host_mask, 32'h0);
        chk("R1 pins", {30'h0, int_pri_n, int_alt_n}, 32'h3);
        chk("R1 msi", {31'h0, msi_req}, 32'h0);
        chk("R1 rpl port", rpl_rdata, 32'hFFFF_FFFF);
        chk("R1 req port", req_rdata, 32'hFFFF_FFFF);

        // R2 doorbell write
        db_write(32'hA5A5_0001);
        chk("R2 value", host_db_value, 32'hA5A5_0001);
        chk("R2 status", host_status, 32'h1);

        // R9 R10 R8 routing table with doorbell pending
        foreach (VEC[i]) begin
            msi_en = VEC[i][3];
            mask_write({22'h0, VEC[i][5:4], 7'h0, VEC[i][2]});
            chk("R9 R10 R8 pins", {30'h0, int_pri_n, int_alt_n}, {30'h0, VEC[i][1:0]});
            chk("R8 status kept", host_status, 32'h1);
        end
        chk("R8 mask readback", host_mask, 32'h0000_0201);
        msi_en = 0;
        mask_write(32'h0);

        // R3 clear semantics
        stat_write(32'h0000_0008);
        chk("R3 no-op clear", host_status, 32'h1);
        stat_write(32'h0000_0001);
        chk("R3 clear", host_status, 32'h0);
        chk("R3 pins released", {30'h0, int_pri_n, int_alt_n}, 32'h3);
        iop_db_we = 1; iop_db_data = 32'h0000_BEEF;
        host_stat_we = 1; host_stat_wdata = 32'h1; tick();
        chk("R3 write wins", host_status, 32'h1);
        chk("R3 new value", host_db_value, 32'h0000_BEEF);
        stat_write(32'h1);

        // R11 MSI pulses
        msi_en = 1;
        db_write(32'h2);
        chk("R11 pulse", {31'h0, msi_req}, 32'h1);
        chk("R10 pins under msi", {30'h0, int_pri_n, int_alt_n}, 32'h3);
        tick();
        chk("R11 single cycle", {31'h0, msi_req}, 32'h0);
        db_write(32'h3);
        chk("R11 no pulse while high", {31'h0, msi_req}, 32'h0);
        stat_write(32'h1);
        db_write(32'h4);
        chk("R11 second pulse", {31'h0, msi_req}, 32'h1);
        stat_write(32'h1);
        msi_en = 0;

        // R4 R5 reply queue
        rpl_in(32'h11);
        chk("R4 bit set", host_status, 32'h8);
        chk("R4 pin", {31'h0, int_pri_n}, 32'h0);
        rpl_in(32'h22);
        rpl_in(32'h33);
        rpl_take("R5 head1", 32'h11);
        rpl_take("R5 head2", 32'h22);
        chk("R4 still set", host_status, 32'h8);
        rpl_take("R5 head3", 32'h33);
        chk("R4 cleared", host_status, 32'h0);
        chk("R5 empty port", rpl_rdata, 32'hFFFF_FFFF);
        rpl_pop = 1; tick();
        chk("R5 empty pop", rpl_rdata, 32'hFFFF_FFFF);
        rpl_in(32'h44);
        chk("R5 after empty pop", rpl_rdata, 32'h44);

        // R8 reply mask
        mask_write(32'h8);
        chk("R8 reply masked pin", {31'h0, int_pri_n}, 32'h1);
        chk("R8 reply status kept", host_status, 32'h8);
        mask_write(32'h0);
        chk("R8 reply unmasked pin", {31'h0, int_pri_n}, 32'h0);
        rpl_take("R5 head4", 32'h44);

        // R7 full reply queue
        for (int k = 1; k <= 5; k++) rpl_in(32'(k));
        for (int k = 1; k <= 4; k++) rpl_take("R7 kept entry", 32'(k));
        chk("R7 fifth dropped", rpl_rdata, 32'hFFFF_FFFF);

        // R6 request queue
        chk("R6 empty", req_rdata, 32'hFFFF_FFFF);
        free_push = 1; free_push_data = 32'h1000; tick();
        free_push = 1; free_push_data = 32'h2000; tick();
        chk("R6 first", req_rdata, 32'h1000);
        req_pop = 1; tick();
        chk("R6 second", req_rdata, 32'h2000);
        req_pop = 1; tick();
        chk("R6 drained", req_rdata, 32'hFFFF_FFFF);
        chk("R1 pins idle", {30'h0, int_pri_n, int_alt_n}, 32'h3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule